// File: doc/BRIEF.md
# Loop-Unrolled Digital Decision Feedback Equalizer

This block cancels post-cursor inter-symbol interference on a digitised serial stream. Each clock that carries a new received sample, the block subtracts a weighted sum of its own earlier decisions from the sample. It then compares the result with a programmable threshold and produces a one-bit decision. The decisions of the last `NTAPS` symbols are kept in a shift chain. Each one is weighted by a signed coefficient that comes from configuration registers outside the block.

The most recent decision has the shortest loop. It is taken out of the loop by speculation. Two comparisons run in parallel, one assuming the previous decision was +1 and one assuming it was −1. The real previous decision then picks the matching result. The older decisions are summed and subtracted directly.

Only post-cursors are cancelled. Interference from symbols that have not yet been decided passes through uncorrected. A wrong decision is fed back like any other decision, so errors propagate through the chain.

Top module: `dfe_loop_unrolled`

## Requirements
- R1: During and after a synchronous active-low reset, `dec_valid` is 0, and every stored past decision is bit 0 (value −1) until new decisions replace it.
- R2: For an accepted sample x, the decision bit is 1 exactly when x − Σ(k=1..NTAPS) c_k·s_k ≥ threshold. Here c_k is the signed tap held in bits [(k−1)·COEF_W +: COEF_W] of `tap_coefs`, and s_k is +1 if the decision k symbols earlier was bit 1, or −1 if it was bit 0. A tie decides 1.
- R3: A sample accepted with `smp_valid` high at one rising edge yields `dec_valid` high and its decision on `dec_bit` for the following cycle, a fixed latency of one cycle.
- R4: A clock without `smp_valid` leaves the past decisions and `dec_bit` unchanged and gives `dec_valid` 0. Decisions older than NTAPS accepted symbols have no effect on the output.
- R5: The kept decision equals the speculative candidate computed for the actual previous decision. With c_1 ≥ 0, a candidate that assumed +1 deciding 1 implies the one that assumed −1 also decides 1.
- R6: The decision is exact, with no overflow, at the extreme inputs: sample −128 or +127, every tap at −128 or +127, and the threshold at either end of its range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A new received sample is present |
| smp_data | input | SMP_W | Received sample, signed two's complement |
| tap_coefs | input | NTAPS*COEF_W | Signed tap weights, tap k in bits [(k−1)·COEF_W +: COEF_W] |
| slice_thr | input | SMP_W | Slicer threshold, signed |
| dec_valid | output | 1 | Decision on dec_bit is new this cycle |
| dec_bit | output | 1 | Decision, 1 means +1 and 0 means −1 |

## Verification
The embedded assertions check three things on every cycle: the history chain shifts only on accepted samples, the one-cycle valid latency holds, and the kept decision is the candidate selected by the real previous decision. They also check that the two speculative candidates are consistently ordered for a non-negative first tap. The arithmetic itself can only be shown by the bench's scenarios. These scenarios cover the exact decision value against an independent signed model, tie handling at the threshold, the −1 history left by reset, error propagation with large taps, and range extremes that would overflow a narrow sum.

// File: rtl/dfe_pkg.sv
// Shared sizing for the loop-unrolled equalizer.
// Assumes two's complement samples, coefficients and threshold.
package dfe_pkg;
    localparam int SMP_W_DEF  = 8;
    localparam int COEF_W_DEF = 8;
    localparam int NTAPS_DEF  = 4;

    // Width holding the sum of nterms signed values of width w, plus a sign guard bit.
    function automatic int acc_width(input int w, input int nterms);
        return w + $clog2(nterms) + 1;
    endfunction
endpackage

// File: rtl/dfe_history.sv
// Decision history: hist[0] is the previous decision, hist[k-1] the one k symbols back.
// Shifts only when a sample is accepted; reset fills it with bit 0 (value -1).
module dfe_history #(
    parameter int NTAPS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             new_dec,
    output logic [NTAPS-1:0] hist
);
    // Shift register of past decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (adv) begin
            hist[0] <= new_dec;
            for (int i = 1; i < NTAPS; i++) hist[i] <= hist[i-1];
        end
    end

    // R4
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(hist));

    generate
        if (NTAPS > 1) begin : g_shift_chk
            // R4
            hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                adv |=> hist[NTAPS-1:1] == $past(hist[NTAPS-2:0]));
        end
    endgenerate
endmodule

// File: rtl/dfe_tail_sum.sv
// Direct feedback sum of taps 2..NTAPS: each contributes +c_k for bit 1 and -c_k for bit 0.
// Combinational; result width ACC_W must hold NTAPS+2 terms.
module dfe_tail_sum #(
    parameter int NTAPS  = 4,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 12
) (
    input  logic [NTAPS*COEF_W-1:0] coefs,
    input  logic [NTAPS-1:0]        hist,
    output logic signed [ACC_W-1:0] tail
);
    logic signed [ACC_W-1:0] term [NTAPS];

    genvar k;
    generate
        for (k = 0; k < NTAPS; k++) begin : g_term
            if (k == 0) begin : g_skip
                // Tap 1 is resolved speculatively elsewhere.
                assign term[k] = '0;
            end else begin : g_use
                logic signed [COEF_W-1:0] c;
                assign c = coefs[k*COEF_W +: COEF_W];
                // Signed weight of one delayed decision.
                assign term[k] = hist[k] ? ACC_W'(c) : -ACC_W'(c);
            end
        end
    endgenerate

    // Adder over all tail terms.
    always_comb begin
        tail = '0;
        for (int i = 0; i < NTAPS; i++) tail = tail + term[i];
    end
endmodule

// File: rtl/dfe_spec_slicer.sv
// Speculative tap-1 slicer: forms both decisions, one per assumed sign of the previous symbol.
// A tie against the threshold decides 1.
module dfe_spec_slicer #(
    parameter int SMP_W  = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 12
) (
    input  logic signed [SMP_W-1:0]  smp,
    input  logic signed [SMP_W-1:0]  thr,
    input  logic signed [COEF_W-1:0] c1,
    input  logic signed [ACC_W-1:0]  tail,
    output logic                     cand_pos,
    output logic                     cand_neg
);
    logic signed [ACC_W-1:0] base, m_pos, m_neg;

    // Sample less tail feedback less threshold, then both tap-1 hypotheses.
    always_comb begin
        base     = ACC_W'(smp) - tail - ACC_W'(thr);
        m_pos    = base - ACC_W'(c1);
        m_neg    = base + ACC_W'(c1);
        cand_pos = !m_pos[ACC_W-1];
        cand_neg = !m_neg[ACC_W-1];
    end

    // R5
    always_comb begin
        spec_order_chk: assert (!(!c1[COEF_W-1] && cand_pos) || cand_neg);
    end
endmodule

// File: rtl/dfe_loop_unrolled.sv
// Top of the decision feedback equalizer with tap-1 loop unrolling.
// One sample per accepted clock; decision and its valid appear one cycle later.
// Assumes tap_coefs and slice_thr are quasi-static configuration values.
module dfe_loop_unrolled #(
    parameter int SMP_W  = dfe_pkg::SMP_W_DEF,
    parameter int COEF_W = dfe_pkg::COEF_W_DEF,
    parameter int NTAPS  = dfe_pkg::NTAPS_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [SMP_W-1:0]        smp_data,
    input  logic [NTAPS*COEF_W-1:0] tap_coefs,
    input  logic [SMP_W-1:0]        slice_thr,
    output logic                    dec_valid,
    output logic                    dec_bit
);
    localparam int TERM_W = (SMP_W > COEF_W) ? SMP_W : COEF_W;
    localparam int ACC_W  = dfe_pkg::acc_width(TERM_W, NTAPS + 2);

    logic [NTAPS-1:0]        hist;
    logic signed [ACC_W-1:0] tail;
    logic                    cand_pos, cand_neg, chosen;
    logic                    valid_q;

    dfe_tail_sum #(.NTAPS(NTAPS), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_tail (
        .coefs(tap_coefs), .hist(hist), .tail(tail)
    );

    dfe_spec_slicer #(.SMP_W(SMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_slice (
        .smp(smp_data), .thr(slice_thr), .c1(tap_coefs[COEF_W-1:0]),
        .tail(tail), .cand_pos(cand_pos), .cand_neg(cand_neg)
    );

    // 2:1 select by the actual previous decision.
    assign chosen = hist[0] ? cand_pos : cand_neg;

    dfe_history #(.NTAPS(NTAPS)) u_hist (
        .clk(clk), .rst_n(rst_n), .adv(smp_valid), .new_dec(chosen), .hist(hist)
    );

    // Output valid tracks accepted samples with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= smp_valid;
    end

    assign dec_valid = valid_q;
    assign dec_bit   = hist[0];

    // R3
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(smp_valid));

    // R5
    spec_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> dec_bit == $past(hist[0] ? cand_pos : cand_neg));

    // R1
    reset_hist_chk: assert property (@(posedge clk)
        !rst_n |=> (hist == '0) && !dec_valid);
endmodule

// File: tb/tb_dfe_loop_unrolled.sv
module tb_dfe_loop_unrolled;
    localparam int SMP_W = 8, COEF_W = 8, NTAPS = 4;

    logic clk = 0, rst_n = 0, smp_valid = 0;
    logic [SMP_W-1:0] smp_data = '0, slice_thr = '0;
    logic [NTAPS*COEF_W-1:0] tap_coefs = '0;
    logic dec_valid, dec_bit;

    int total = 0, bad = 0;
    bit done = 0;
    int coef [NTAPS];
    bit mhist [NTAPS];
    bit last_out = 0;

    always #10 clk = ~clk;  // 50 MHz

    dfe_loop_unrolled #(.SMP_W(SMP_W), .COEF_W(COEF_W), .NTAPS(NTAPS)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .tap_coefs(tap_coefs), .slice_thr(slice_thr),
        .dec_valid(dec_valid), .dec_bit(dec_bit)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_coefs();
        for (int k = 0; k < NTAPS; k++) tap_coefs[k*COEF_W +: COEF_W] = COEF_W'(coef[k]);
    endtask

    // Reference decision from the R2 rule.
    function automatic bit model_dec(input int x, input int thr);
        int fb = 0;
        for (int k = 0; k < NTAPS; k++) fb += mhist[k] ? coef[k] : -coef[k];
        return (x - fb) >= thr;
    endfunction

    // Drive one cycle at a falling edge, check after the next rising edge.
    task automatic step(input bit v, input int x, input int thr, input string req);
        bit e;
        smp_valid = v; smp_data = SMP_W'(x); slice_thr = SMP_W'(thr);
        e = v ? model_dec(x, thr) : last_out;
        if (v) begin
            for (int k = NTAPS-1; k > 0; k--) mhist[k] = mhist[k-1];
            mhist[0] = e;
        end
        @(posedge clk); @(negedge clk);
        check({req, "/R3 valid"}, dec_valid, v);
        check(v ? req : "R4 hold", dec_bit, e);
        last_out = e;
    endtask

    task automatic do_reset();
        rst_n = 0; smp_valid = 0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", dec_valid, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 valid after reset", dec_valid, 0);
        for (int k = 0; k < NTAPS; k++) mhist[k] = 0;
        last_out = 0;
    endtask

    initial begin
        process::self().srandom(32'h5eed_d0fe);
        @(negedge clk);
        // R1: history starts at -1. c1=10, x=-9: -9+10=1 >= 0 -> 1 (would be 0 if +1).
        coef = '{10, 0, 0, 0}; load_coefs();
        do_reset();
        step(1, -9, 0, "R1 first decision");
        // R2 tie: history now {1,0,0,0}; fb = 10 -> x=15, thr=5 gives exactly 5 -> 1.
        step(1, 15, 5, "R2 tie");
        step(1, 14, 5, "R2 below tie");
        // R4 gaps hold.
        step(0, 100, 0, "R4");
        step(0, -100, 0, "R4");
        // R5 error propagation with a dominant tap 1.
        coef = '{60, 0, 0, 0}; load_coefs();
        for (int i = 0; i < 6; i++) step(1, 0, 0, "R5 propagate");
        // R4: taps beyond NTAPS ignored; only tap 4 weighted.
        coef = '{0, 0, 0, 50}; load_coefs();
        for (int i = 0; i < 12; i++) step(1, (i % 3 == 0) ? 40 : -40, 0, "R4 window");
        // R6 extremes.
        coef = '{127, 127, 127, 127}; load_coefs();
        for (int i = 0; i < 6; i++) step(1, 127, -128, "R6 max");
        step(1, -128, 127, "R6 min");
        coef = '{-128, -128, -128, -128}; load_coefs();
        for (int i = 0; i < 6; i++) step(1, (i < 3) ? -128 : 127, (i < 3) ? 127 : -128, "R6 neg taps");
        // Random mix against the model.
        for (int blk = 0; blk < 20; blk++) begin
            for (int k = 0; k < NTAPS; k++)
                coef[k] = (blk % 2) ? $signed(8'($urandom)) : int'($urandom_range(0, 40)) - 20;
            load_coefs();
            for (int i = 0; i < 150; i++)
                step($urandom_range(0, 3) != 0, $signed(8'($urandom)),
                     int'($urandom_range(0, 16)) - 8, "R2 random");
        end
        // Reset mid-stream returns the history to -1.
        coef = '{10, 0, 0, 0}; load_coefs();
        do_reset();
        step(1, -9, 0, "R1 after second reset");
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule